// File: doc/BRIEF.md
# Serial EEPROM Page Write Engine

This block is the write-side controller of a small two-wire serial EEPROM that holds 128 or 256 bytes. A separate bit-level front end turns the bus into byte-level events: start seen, stop seen, and byte received. The engine answers every received byte with an acknowledge decision on the same cycle. It takes a device command byte, then a word address, then any number of data bytes into an eight-slot page buffer, and it marks which slots were loaded.

When a stop arrives after at least one data byte, the engine runs an internally timed programming cycle on the page. The first half of the cycle sets every loaded location to 0xFF. The second half stores the buffered values there. Locations that were not loaded keep their contents. While the cycle runs, command bytes are refused, so a host can poll for the end of the cycle by repeating a command until it is acknowledged. A combinational read port on the storage array serves the separate read path.

Top module: `ee_page_wr_engine`

## Requirements
- R1: A command byte is acknowledged only if its bits [7:4] equal the device code (default 4'b1010), its bit 0 is 0 (write), and no programming cycle is running. The word-address byte and every data byte of an accepted transfer are acknowledged.
- R2: The first data byte is stored at the word address (its low log2(DEPTH) bits). After each acknowledged data byte the pointer moves to the next location.
- R3: Only address bits [2:0] take part in the increment, and they wrap from 7 to 0. The bits above them stay fixed, so one transfer never leaves its 8-byte page.
- R4: The storage array does not change while data bytes are being received. It changes only after the stop.
- R5: A stop that follows at least one acknowledged data byte starts programming. `busy` is then high for exactly PROG_CYCLES clock cycles, beginning on the cycle after the stop event.
- R6: During the first PROG_CYCLES/2 cycles every loaded location reads 0xFF. At the end of the cycle it holds the last byte loaded for it.
- R7: Locations of the page that were not loaded keep their old contents during and after programming.
- R8: While `busy` is high, command bytes get no acknowledge. After `busy` falls, the same command is acknowledged again.
- R9: If the pointer wraps and loads a slot a second time within one transfer, the later byte is the one that gets programmed.
- R10: A stop, or a repeated start followed by a stop, that comes before any data byte was acknowledged does not start programming.
- R11: A byte received outside an accepted transfer is not acknowledged and has no effect on storage. This covers a byte before any start, a byte after a refused command, and a command with the wrong device code or with the read bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the array resets to 0xFF |
| ev_start | input | 1 | One-cycle strobe: start condition seen |
| ev_stop | input | 1 | One-cycle strobe: stop condition seen |
| ev_byte | input | 1 | One-cycle strobe: a byte was received |
| rx_byte | input | 8 | Value of the received byte, valid with ev_byte |
| ack | output | 1 | Acknowledge decision for the byte on rx_byte, valid while ev_byte is high |
| busy | output | 1 | Programming cycle in progress |
| rd_addr | input | log2(DEPTH) | Read address into the storage array |
| rd_data | output | 8 | Array contents at rd_addr (combinational) |

## Verification
The hardest state to reach is the middle of the erase half, when loaded locations already read 0xFF and their unloaded neighbours in the same page must still hold older, non-erased data. The bench first fills pages with known random bytes. It then writes partial and wrapping transfers on top of them and reads the page through the read port a few cycles after the stop, well inside the shortened erase window. Polling during the cycle, stops that come before any data byte, and transfers longer than eight bytes are applied as directed cases. Random transfers of 1 to 12 bytes at random addresses run between them and are checked against a bench model of the array.

// File: rtl/ee_pw_pkg.sv
// Package: shared types and constants of the serial EEPROM page write engine.
// Assumes one page is eight bytes, so the slot index is three bits wide.
package ee_pw_pkg;
    localparam int PAGE_BYTES = 8;
    localparam int SLOT_W     = 3;

    // Transfer-level state of the write controller
    typedef enum logic [2:0] {
        CS_IDLE,   // no transfer, waiting for a start
        CS_CMD,    // next byte is the command byte
        CS_ADDR,   // next byte is the word address
        CS_DATA,   // data bytes go into the page buffer
        CS_HOLD    // command refused, ignore bytes until a start
    } ctrl_st_e;

    // Phase of the timed programming cycle
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ERASE,
        PH_WRITE
    } prog_ph_e;
endpackage

// File: rtl/ee_pw_ctrl.sv
// Module: transfer controller. Decodes start, stop and byte events into
// command, address and data phases, decides the acknowledge, and drives the
// page pointer and the buffer strobes.
// Assumes: at most one of ev_start / ev_stop / ev_byte per cycle, with the
// priority stop > start > byte if they coincide; busy comes from the timer.
module ee_pw_ctrl
    import ee_pw_pkg::*;
#(
    parameter int          AW       = 8,
    parameter logic [3:0]  DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_byte,
    input  logic [7:0]        rx_byte,
    input  logic              busy,
    input  logic              any_loaded,
    output logic              ack,
    output logic              buf_wr,
    output logic              buf_clr,
    output logic [SLOT_W-1:0] slot,
    output logic [AW-4:0]     page,
    output logic              kick
);
    localparam int PW = AW - SLOT_W;

    ctrl_st_e          state_q;
    logic [PW-1:0]     page_q;
    logic [SLOT_W-1:0] ptr_q;
    logic              byte_ev;
    logic              cmd_ok;

    // A byte counts only when no bus condition arrives in the same cycle
    assign byte_ev = ev_byte && !ev_start && !ev_stop;

    // Command acceptance: device code, write direction, array not busy
    assign cmd_ok = (rx_byte[7:4] == DEV_CODE) && !rx_byte[0] && !busy;

    // Acknowledge decision for the byte presented this cycle
    always_comb begin
        ack = 1'b0;
        if (byte_ev) begin
            case (state_q)
                CS_CMD:           ack = cmd_ok;
                CS_ADDR, CS_DATA: ack = 1'b1;
                default:          ack = 1'b0;
            endcase
        end
    end

    assign buf_wr  = byte_ev && (state_q == CS_DATA);
    assign buf_clr = byte_ev && (state_q == CS_ADDR);
    assign kick    = ev_stop && (state_q == CS_DATA) && any_loaded;
    assign slot    = ptr_q;
    assign page    = page_q;

    // Transfer state, page register and in-page pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            page_q  <= '0;
            ptr_q   <= '0;
        end else if (ev_stop) begin
            state_q <= CS_IDLE;
        end else if (ev_start) begin
            state_q <= CS_CMD;
        end else if (ev_byte) begin
            case (state_q)
                CS_CMD:  state_q <= cmd_ok ? CS_ADDR : CS_HOLD;
                CS_ADDR: begin
                    page_q  <= rx_byte[AW-1:SLOT_W];
                    ptr_q   <= rx_byte[SLOT_W-1:0];
                    state_q <= CS_DATA;
                end
                CS_DATA: ptr_q <= ptr_q + SLOT_W'(1);
                default: state_q <= state_q;
            endcase
        end
    end

    // R2: each stored data byte moves the pointer on by one (mod 8)
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> ptr_q == SLOT_W'($past(ptr_q) + SLOT_W'(1)));

    // R3: the page bits never move while data bytes are entered
    a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> $stable(page_q));
endmodule

// File: rtl/ee_pw_pagebuf.sv
// Module: eight-slot page buffer with a per-slot loaded mask.
// Assumes clr and wr are never high together (address vs data phase).
// A second write to a slot replaces the earlier byte.
module ee_pw_pagebuf
    import ee_pw_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       wr,
    input  logic [SLOT_W-1:0]          wr_slot,
    input  logic [7:0]                 wr_data,
    output logic [PAGE_BYTES-1:0][7:0] data,
    output logic [PAGE_BYTES-1:0]      mask
);
    logic [PAGE_BYTES-1:0][7:0] data_q;
    logic [PAGE_BYTES-1:0]      mask_q;

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        // One buffer slot: capture data and set its loaded flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[s] <= '0;
                mask_q[s] <= 1'b0;
            end else if (clr) begin
                mask_q[s] <= 1'b0;
            end else if (wr && (wr_slot == SLOT_W'(s))) begin
                data_q[s] <= wr_data;
                mask_q[s] <= 1'b1;
            end
        end
    end

    assign data = data_q;
    assign mask = mask_q;

    // R9: a new word address leaves no slot marked as loaded
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> mask_q == '0);
endmodule

// File: rtl/ee_pw_timer.sv
// Module: programming cycle timer. A kick while idle runs an erase phase and
// then a write phase of PROG_CYCLES/2 clocks each, with one pulse at the start
// of each phase. Assumes PROG_CYCLES is even and at least 2.
module ee_pw_timer
    import ee_pw_pkg::*;
#(
    parameter int PROG_CYCLES = 1_600_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic erase_pulse,
    output logic write_pulse,
    output logic busy
);
    localparam int HALF  = PROG_CYCLES / 2;
    localparam int CNT_W = $clog2(HALF + 1);

    prog_ph_e         ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q == CNT_W'(HALF - 1));

    // Phase sequencer: idle -> erase -> write -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (kick) ph_q <= PH_ERASE;
                end
                PH_ERASE: begin
                    cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
                    if (last) ph_q <= PH_WRITE;
                end
                PH_WRITE: begin
                    cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
                    if (last) ph_q <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign erase_pulse = (ph_q == PH_ERASE) && (cnt_q == '0);
    assign write_pulse = (ph_q == PH_WRITE) && (cnt_q == '0);
    assign busy        = (ph_q != PH_IDLE);

    // R6: the write step always comes right after the erase phase
    a_r6_write_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
        write_pulse |-> $past(ph_q) == PH_ERASE);

    // R5: a kick from idle makes the block busy on the next cycle
    a_r5_kick_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !busy) |=> busy);
endmodule

// File: rtl/ee_pw_array.sv
// Module: register-array storage. Masked page write port, combinational read
// port. Resets to 0xFF, the erased state. Assumes DEPTH is a power of two
// and at least one page.
module ee_pw_array
    import ee_pw_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pg_we,
    input  logic [$clog2(DEPTH)-4:0]   pg_idx,
    input  logic [PAGE_BYTES-1:0][7:0] pg_data,
    input  logic [PAGE_BYTES-1:0]      pg_mask,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [7:0]                 rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0] mem_q [DEPTH];

    // Storage: reset to erased, then program only masked slots of one page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (pg_we) begin
            for (int s = 0; s < PAGE_BYTES; s++) begin
                if (pg_mask[s]) mem_q[{pg_idx, SLOT_W'(s)}] <= pg_data[s];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/ee_page_wr_engine.sv
// Module: top of the serial EEPROM page write engine. Connects the transfer
// controller, page buffer, programming timer and storage array. The erase
// step writes 0xFF into the loaded slots; the write step writes the buffer.
// Assumes byte-level events from a separate bit-level bus front end.
module ee_page_wr_engine
    import ee_pw_pkg::*;
#(
    parameter int         DEPTH       = 256,
    parameter int         PROG_CYCLES = 1_600_000,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ev_start,
    input  logic                     ev_stop,
    input  logic                     ev_byte,
    input  logic [7:0]               rx_byte,
    output logic                     ack,
    output logic                     busy,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [7:0]               rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic                       buf_wr, buf_clr, kick;
    logic [SLOT_W-1:0]          slot;
    logic [AW-4:0]              page;
    logic [PAGE_BYTES-1:0][7:0] buf_data, pg_data;
    logic [PAGE_BYTES-1:0]      buf_mask;
    logic                       erase_pulse, write_pulse, pg_we;

    ee_pw_ctrl #(.AW(AW), .DEV_CODE(DEV_CODE)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte(ev_byte),
        .rx_byte(rx_byte), .busy(busy), .any_loaded(|buf_mask),
        .ack(ack), .buf_wr(buf_wr), .buf_clr(buf_clr),
        .slot(slot), .page(page), .kick(kick)
    );

    ee_pw_pagebuf u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr(buf_wr),
        .wr_slot(slot), .wr_data(rx_byte), .data(buf_data), .mask(buf_mask)
    );

    ee_pw_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .kick(kick),
        .erase_pulse(erase_pulse), .write_pulse(write_pulse), .busy(busy)
    );

    // Page data source: all ones while erasing, buffer contents while writing
    assign pg_data = erase_pulse ? {PAGE_BYTES{8'hFF}} : buf_data;
    assign pg_we   = erase_pulse || write_pulse;

    ee_pw_array #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .pg_we(pg_we), .pg_idx(page),
        .pg_data(pg_data), .pg_mask(buf_mask),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R4: the buffer never takes data while the array is being programmed
    a_r4_no_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> !busy);

    // R10: the array is only ever programmed with at least one loaded slot
    a_r10_prog_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        pg_we |-> buf_mask != '0);

    // R8: no transfer can restart programming while a cycle is running
    a_r8_kick_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> !busy);
endmodule

// File: tb/ee_page_wr_engine_tb.sv
// Bench: directed corner cases plus seeded random transfers, checked against
// a byte-array model of the storage kept in the bench.
module ee_page_wr_engine_tb_top;
    localparam int DEPTH = 256;
    localparam int PROG  = 40;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          ack, busy;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int checks = 0, errors = 0, busy_run = 0, cyc = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [DEPTH];
    logic [7:0] pbuf [8];
    logic [7:0] pmask;
    int         ppage;

    ee_page_wr_engine #(.DEPTH(DEPTH), .PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte(ev_byte), .rx_byte(rx_byte), .ack(ack), .busy(busy),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        if (busy) busy_run++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        rd_addr = AW'(a);
        #0.2;
        v = rd_data;
    endtask

    task automatic bus_start();
        @(negedge clk); ev_start = 1'b1;
        @(negedge clk); ev_start = 1'b0;
    endtask

    task automatic bus_stop();
        @(negedge clk); ev_stop = 1'b1;
        @(negedge clk); ev_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, output logic ak);
        @(negedge clk); ev_byte = 1'b1; rx_byte = b;
        #1 ak = ack;
        @(negedge clk); ev_byte = 1'b0;
    endtask

    // Compare the whole array with the model (R2, R3, R7, R9 end state)
    task automatic compare_all(input string req);
        int bad = 0, first = -1;
        logic [7:0] v, fv, fe;
        fv = '0; fe = '0;
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, v);
            if (v !== ref_mem[a]) begin
                if (first < 0) begin first = a; fv = v; fe = ref_mem[a]; end
                bad++;
            end
        end
        check(bad == 0, req, {first[15:0], fv}, {first[15:0], fe});
    endtask

    // Start, command, address and n data bytes; model the page buffer
    task automatic load(input int a, input int n);
        logic ak;
        logic [7:0] v, d;
        int p;
        bus_start();
        send(8'hA0, ak); check(ak === 1'b1, "R1 command ack", ak, 1);
        send(8'(a), ak); check(ak === 1'b1, "R1 address ack", ak, 1);
        ppage = a & 'hF8; p = a & 7; pmask = '0;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send(d, ak); check(ak === 1'b1, "R2 data ack", ak, 1);
            pbuf[p] = d; pmask[p] = 1'b1; p = (p + 1) % 8;
        end
        rd(a, v); check(v === ref_mem[a], "R4 array unchanged before stop", v, ref_mem[a]);
    endtask

    // Stop, check erase window and cycle length, then the final contents
    task automatic program_and_check(input string req);
        logic [7:0] v;
        busy_run = 0;
        bus_stop();
        repeat (3) @(negedge clk);
        for (int s = 0; s < 8; s++) begin
            rd(ppage + s, v);
            if (pmask[s]) check(v === 8'hFF, "R6 erased during first half", v, 8'hFF);
            else check(v === ref_mem[ppage + s], "R7 unloaded slot kept", v, ref_mem[ppage + s]);
        end
        while (busy) @(negedge clk);
        check(busy_run == PROG, "R5 busy length", busy_run, PROG);
        for (int s = 0; s < 8; s++) if (pmask[s]) ref_mem[ppage + s] = pbuf[s];
        compare_all(req);
    endtask

    // Expect no programming to start in the next few cycles
    task automatic expect_idle(input string req);
        bit seen = 1'b0;
        repeat (4) begin @(negedge clk); if (busy) seen = 1'b1; end
        check(!seen, req, seen, 0);
    endtask

    initial begin
        logic ak;
        logic [7:0] v;
        int polls;
        void'($urandom(32'h1234_5eed));
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0, "R5 busy low after reset", busy, 0);
        check(ack === 1'b0, "R1 ack low after reset", ack, 0);
        rd(8'h10, v); check(v === 8'hFF, "R4 array erased after reset", v, 8'hFF);

        // R11: byte before any start, bad device code, read bit
        send(8'hA0, ak); check(ak === 1'b0, "R11 byte before start nacked", ak, 0);
        bus_start();
        send(8'hB0, ak); check(ak === 1'b0, "R11 wrong device code nacked", ak, 0);
        send(8'h12, ak); check(ak === 1'b0, "R11 byte after refusal nacked", ak, 0);
        bus_stop(); expect_idle("R11 no programming after refusal");
        bus_start();
        send(8'hA1, ak); check(ak === 1'b0, "R11 read bit nacked", ak, 0);
        bus_stop();
        compare_all("R11 array untouched");

        // Fill pages 0x10 and 0x20 fully, then partial and wrapping transfers
        load(8'h10, 8); program_and_check("R2 full page");
        load(8'h20, 8); program_and_check("R2 second page");
        load(8'h15, 3); program_and_check("R7 partial page");
        load(8'h26, 4); program_and_check("R3 wrap inside page");
        load(8'h30, 11); program_and_check("R9 later byte wins");

        // R10: stop after address only; repeated start then stop
        load(8'h40, 0); bus_stop(); expect_idle("R10 stop without data");
        load(8'h41, 0); bus_start(); bus_stop(); expect_idle("R10 restart without data");
        compare_all("R10 array untouched");

        // R8: acknowledge polling
        load(8'h52, 2);
        busy_run = 0;
        bus_stop();
        polls = 0;
        bus_start(); send(8'hA0, ak);
        check(ak === 1'b0, "R8 command nacked while busy", ak, 0);
        while (ak !== 1'b1 && polls < 100) begin
            bus_stop(); polls++;
            bus_start(); send(8'hA0, ak);
        end
        check(ak === 1'b1 && busy === 1'b0, "R8 command acked after cycle", ak, 1);
        bus_stop(); expect_idle("R10 poll ends without programming");
        for (int s = 0; s < 8; s++) if (pmask[s]) ref_mem[ppage + s] = pbuf[s];
        compare_all("R8 polled write landed");

        // Random transfers
        for (int t = 0; t < 40; t++) begin
            load(int'($urandom_range(DEPTH - 1)), int'($urandom_range(12, 1)));
            program_and_check("R2 random transfer");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule